// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two signed two's-complement operands over several clock cycles using a single adder/subtractor and a shifting accumulator. Each cycle it looks at one adjacent bit pair of the multiplier and makes one recoding decision. At the bottom of a run of ones it subtracts the multiplicand. At the first zero above that run it adds the multiplicand. Pairs of equal bits cause no arithmetic. A long run of ones therefore costs two operations rather than one per bit.

When the choice is enabled, the block first counts the runs of ones in each operand. It uses the operand with fewer runs as the multiplier, which lowers the number of add/subtract operations. The product does not depend on that choice. A caller pulses `start` while the block is idle, waits for the one-cycle `done` pulse, and then reads the 2W-bit product together with the number of arithmetic operations that were performed. Both results stay on the outputs until the next job finishes.

Top module: `booth_seq_mul`

## Requirements
- R1: When a job finishes, `product` equals the signed product of `op_a` and `op_b` as a 2W-bit two's-complement value. This holds for every operand pair, including the most negative value times itself.
- R2: Suppose `start` is sampled high while `busy` is low at a rising edge. Then `busy` is high for the next W cycles, and after the W-th following edge `done` is high for exactly one cycle while `busy` is low.
- R3: A `start` pulse sampled while `busy` is high is ignored. The result and the finish cycle of the running job are unchanged.
- R4: The multiplier bit i and bit i-1 form a pair, where bit -1 is taken as 0. The pair (1,0) subtracts, the pair (0,1) adds, and the pairs (0,0) and (1,1) cause no arithmetic.
- R5: `op_count` equals the number of bit positions i in 0..W-1 where multiplier bit i differs from bit i-1. For example, the multiplier 8'b00111111 gives 2.
- R6: With `pick_en` high, `op_a` becomes the multiplier only if it has strictly fewer runs of ones than `op_b`. On a tie, `op_b` stays the multiplier.
- R7: With `pick_en` low, `op_b` is always the multiplier.
- R8: After reset, `busy`, `done`, `product` and `op_count` are all zero.
- R9: While the block is idle, `product` and `op_count` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job when sampled high while idle |
| pick_en | input | 1 | Enables choosing the operand with fewer runs as multiplier |
| op_a | input | W | Signed operand A |
| op_b | input | W | Signed operand B, multiplier by default |
| busy | output | 1 | High while a job is in progress |
| done | output | 1 | One-cycle pulse when a result is written |
| product | output | 2W | Signed product of the last finished job |
| op_count | output | clog2(W+1) | Add/subtract operations of the last finished job |

## Verification
A wrong recoding decision or a wrong accumulator bit shows up at `done` as an incorrect `product`, and that error appears within the same job. A wrong swap decision leaves the product correct but shows up in `op_count`. For this reason the tie and asymmetric run cases are chosen so that the two possible multipliers give different counts. A miscounted step counter moves the `done` pulse, which the bench catches by measuring latency from `start`. A start that is wrongly accepted while busy corrupts the result of the job that is running.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    DIG_NONE = 2'd0,
    DIG_ADD  = 2'd1,
    DIG_SUB  = 2'd2
  } booth_dig_e;
endpackage

// File: rtl/booth_run_count.sv
module booth_run_count #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  opnd,
  output logic [CW-1:0] runs
);
  // A run of ones starts at bit i when bit i is set and bit i-1 (0 below LSB) is clear.
  logic [W-1:0] starts;

  for (genvar i = 0; i < W; i++) begin : g_start
    if (i == 0) begin : g_lsb
      assign starts[i] = opnd[0];
    end else begin : g_upper
      assign starts[i] = opnd[i] & ~opnd[i-1];
    end
  end

  always_comb begin
    runs = '0;
    for (int k = 0; k < W; k++) begin
      runs = runs + CW'(starts[k]);
    end
  end
endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic       cur_bit,
  input  logic       prev_bit,
  output booth_dig_e dig
);
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   dig = DIG_SUB;
      2'b01:   dig = DIG_ADD;
      default: dig = DIG_NONE;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W:0]   acc,
  input  logic [W-1:0] mcand,
  input  booth_dig_e   dig,
  output logic [W:0]   sum
);
  logic [W:0] mc_ext;
  logic [W:0] operand;
  logic       cin;

  assign mc_ext = {mcand[W-1], mcand};

  always_comb begin
    unique case (dig)
      DIG_SUB: begin
        operand = ~mc_ext;
        cin     = 1'b1;
      end
      DIG_ADD: begin
        operand = mc_ext;
        cin     = 1'b0;
      end
      default: begin
        operand = '0;
        cin     = 1'b0;
      end
    endcase
  end

  assign sum = acc + operand + (W+1)'(cin);
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            pick_en,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            busy,
  output logic            done,
  output logic [2*W-1:0]  product,
  output logic [CW-1:0]   op_count
);
  localparam int SW = (W > 1) ? $clog2(W) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // State
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [SW-1:0]   step_q, step_d;
  logic [W:0]      acc_q, acc_d;
  logic [W-1:0]    mplr_q, mplr_d;
  logic            qm1_q, qm1_d;
  logic [W-1:0]    mcand_q, mcand_d;
  logic [CW-1:0]   ops_q, ops_d;
  logic [2*W-1:0]  prod_q, prod_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  // Operand choice
  logic [CW-1:0] runs_a, runs_b;
  logic          swap;
  logic          accept;

  booth_run_count #(.W(W)) i_runs_a (.opnd(op_a), .runs(runs_a));
  booth_run_count #(.W(W)) i_runs_b (.opnd(op_b), .runs(runs_b));

  assign swap   = pick_en && (runs_a < runs_b);
  assign accept = start && !busy_q;

  // One Booth step
  booth_dig_e dig;
  logic [W:0] sum;

  booth_recode i_recode (.cur_bit(mplr_q[0]), .prev_bit(qm1_q), .dig(dig));

  booth_addsub #(.W(W)) i_addsub (
    .acc(acc_q), .mcand(mcand_q), .dig(dig), .sum(sum)
  );

  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    step_d  = step_q;
    acc_d   = acc_q;
    mplr_d  = mplr_q;
    qm1_d   = qm1_q;
    mcand_d = mcand_q;
    ops_d   = ops_q;
    prod_d  = prod_q;
    cnt_d   = cnt_q;
    if (accept) begin
      busy_d  = 1'b1;
      step_d  = '0;
      acc_d   = '0;
      qm1_d   = 1'b0;
      ops_d   = '0;
      mplr_d  = swap ? op_a : op_b;
      mcand_d = swap ? op_b : op_a;
    end else if (busy_q) begin
      acc_d  = {sum[W], sum[W:1]};
      mplr_d = {sum[0], mplr_q[W-1:1]};
      qm1_d  = mplr_q[0];
      ops_d  = ops_q + CW'(dig != DIG_NONE);
      step_d = step_q + 1'b1;
      if (step_q == SW'(W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        prod_d = {acc_d[W-1:0], mplr_d};
        cnt_d  = ops_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      acc_q   <= '0;
      mplr_q  <= '0;
      qm1_q   <= 1'b0;
      mcand_q <= '0;
      ops_q   <= '0;
      prod_q  <= '0;
      cnt_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      step_q  <= step_d;
      acc_q   <= acc_d;
      mplr_q  <= mplr_d;
      qm1_q   <= qm1_d;
      mcand_q <= mcand_d;
      ops_q   <= ops_d;
      prod_q  <= prod_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign product  = prod_q;
  assign op_count = cnt_q;

  // Checks
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |=> !done_q);

  assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy_q) |-> done_q);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_q)
    done_q |-> !busy_q);

  assert_ops_bound_R5: assert property (@(posedge clk) disable iff (!rst_q)
    busy_q |-> (int'(ops_q) <= int'(step_q)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !busy_q |=> ($stable(prod_q) && $stable(cnt_q)));

  assert_default_order_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && !pick_en) |=> (mplr_q == $past(op_b) && mcand_q == $past(op_a)));

  assert_busy_ignores_start_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (busy_q && step_q != SW'(W - 1)) |=> (busy_q && $stable(mcand_q)));
endmodule

// File: tb/test_booth_seq_mul.sv
module test_booth_seq_mul;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            pick_en = 1'b0;
  logic [W-1:0]    op_a = '0;
  logic [W-1:0]    op_b = '0;
  logic            busy;
  logic            done;
  logic [2*W-1:0]  product;
  logic [CW-1:0]   op_count;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  booth_seq_mul #(.W(W)) i_booth_seq_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .pick_en(pick_en),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .product(product), .op_count(op_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int runs_of(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) begin
      if (v[i] && (i == 0 || !v[i-1])) n++;
    end
    return n;
  endfunction

  function automatic int digits_of(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) begin
      if (v[i] != ((i == 0) ? 1'b0 : v[i-1])) n++;
    end
    return n;
  endfunction

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint p  = sa * sb;
    return p[2*W-1:0];
  endfunction

  // Runs one job; optionally pulses start again mid-job with other operands.
  task automatic run_job(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic pick, input bit poke, input string tag);
    int lat = 0;
    logic [W-1:0] m;
    @(negedge clk);
    op_a = a; op_b = b; pick_en = pick; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 busy"}, busy, 1);
    while (!done && lat < 4 * W) begin
      if (poke && lat == 2) begin
        op_a = ~a; op_b = b ^ 8'h5A; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({tag, " R2 latency"}, lat, W);
    check({tag, " R2 idle at done"}, busy, 0);
    m = (pick && runs_of(a) < runs_of(b)) ? a : b;
    check({tag, " R1 product"}, product, ref_prod(a, b));
    check({tag, " R5 count"}, op_count, digits_of(m));
    @(negedge clk);
    check({tag, " R2 done pulse"}, done, 0);
  endtask

  task automatic t_reset();
    check("R8 busy", busy, 0);
    check("R8 done", done, 0);
    check("R8 product", product, 0);
    check("R8 op_count", op_count, 0);
  endtask

  task automatic t_recode();
    run_job(8'd5, 8'h3F, 1'b0, 1'b0, "R4 run of six");
    check("R4 R5 run of six ops", op_count, 2);
    run_job(8'd7, 8'hFF, 1'b0, 1'b0, "R4 all ones");
    check("R4 all ones ops", op_count, 1);
    run_job(8'd9, 8'h00, 1'b0, 1'b0, "R4 zero");
    check("R4 zero ops", op_count, 0);
  endtask

  task automatic t_extremes();
    run_job(8'h80, 8'h80, 1'b0, 1'b0, "R1 min*min");
    run_job(8'h80, 8'h7F, 1'b0, 1'b0, "R1 min*max");
    run_job(8'h7F, 8'h80, 1'b1, 1'b0, "R1 max*min pick");
    run_job(8'hFF, 8'hFF, 1'b0, 1'b0, "R1 -1*-1");
  endtask

  task automatic t_pick();
    run_job(8'h01, 8'h55, 1'b1, 1'b0, "R6 swap");
    check("R6 swap ops", op_count, 2);
    run_job(8'h01, 8'h55, 1'b0, 1'b0, "R7 no swap");
    check("R7 no swap ops", op_count, 8);
    run_job(8'h0F, 8'hF0, 1'b1, 1'b0, "R6 tie");
    check("R6 tie keeps op_b", op_count, 1);
  endtask

  task automatic t_busy_start();
    run_job(8'h6D, 8'hB3, 1'b0, 1'b1, "R3 start while busy");
    run_job(8'h81, 8'h3C, 1'b1, 1'b1, "R3 start while busy pick");
  endtask

  task automatic t_hold();
    logic [2*W-1:0] p;
    logic [CW-1:0]  c;
    p = product; c = op_count;
    @(negedge clk);
    op_a = 8'h11; op_b = 8'h22;
    repeat (5) @(negedge clk);
    check("R9 product held", product, p);
    check("R9 op_count held", op_count, c);
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr = 16'hACE1;
    for (int n = 0; n < 150; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_job(lfsr[7:0], lfsr[15:8], lfsr[3], 1'b0, "R1 R5 R6 sweep");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_recode();
    t_extremes();
    t_pick();
    t_busy_start();
    t_hold();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule